// File: doc/BRIEF.md
# MIDI Running-Status Message Parser

This block sits behind a serial receiver and turns its stream of received bytes into decoded musical events. Each byte arrives with a one-cycle valid strobe. A running-status register holds the last channel voice status, and a small data-phase state machine pairs the data bytes that follow it. Repeated data pairs can therefore reuse one status without retransmitting it.

Only note-off, note-on and control-change messages on the selected receive channel produce events. Every other voice type, system common and exclusive traffic, and data with no valid status are consumed silently. Real-time bytes may be interleaved anywhere without disturbing the parse. Events leave the block as one-cycle pulses with their data fields held on dedicated outputs.

Top module: `midi_rs_parser`

## Requirements
- R1: After reset both event outputs are low and the running-status register is zero.
- R2: A byte from 0xC0 through 0xF7 clears the running status and returns the data phase to idle, so later data bytes produce no event until a new status arrives.
- R3: A byte of 0xF8 or above changes neither the running status nor the data phase, even between the two data bytes of a pair.
- R4: A byte from 0x80 through 0xBF is stored as the running status and puts the data phase into first-data, also when it arrives in the middle of a pair.
- R5: A data byte (bit 7 clear) that arrives while the running status is zero is discarded.
- R6: In first-data the byte is latched as the note or controller number. In second-data it completes the pair, and the event is reported one clock after the sampling edge of that second byte.
- R7: After a pair completes, the data phase returns to first-data, so further pairs without a status byte reuse the stored status.
- R8: A completed pair raises note_evt_o when the status high nibble is 0x8 or 0x9, and raises cc_evt_o when it is 0xB. In both cases the low nibble must equal chan_i. Status 0xA0 through 0xAF yields no event.
- R9: A status on a channel other than chan_i is still stored, but its pairs raise no event while the channel differs. The channel compare is made when the pair completes.
- R10: note_on_o is 1 only for high nibble 0x9 with a nonzero velocity. A 0x9n pair with velocity zero is reported with note_on_o = 0. note_status_o carries the stored status byte.
- R11: Each event output is high for exactly one cycle, and its data fields hold the completed pair values during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received byte |
| byte_valid_i | input | 1 | byte_i is valid this cycle |
| chan_i | input | 4 | Selected receive channel |
| note_evt_o | output | 1 | Note event pulse |
| note_on_o | output | 1 | 1 = note on, 0 = note off |
| note_status_o | output | 8 | Status byte of the note event |
| note_num_o | output | 7 | Note number |
| note_vel_o | output | 7 | Velocity |
| cc_evt_o | output | 1 | Control-change event pulse |
| cc_num_o | output | 7 | Controller number |
| cc_val_o | output | 7 | Controller value |

## Verification
Two functions can fall in the same cycle: the registered event pulse for a just-completed pair, and the acceptance of the next received byte, which may be a new status, a real-time byte or the first data byte of the next pair. This is provoked by bursts with no idle cycles between bytes. The scoreboard then requires that each pulse carries the fields of the pair it closed, not values from the byte being taken in at the same time. It also requires that two pulses never appear on adjacent cycles.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAN_W = 4;
  localparam int KIND_W = BYTE_W - CHAN_W;
  localparam int DATA_W = BYTE_W - 1;

  localparam logic [BYTE_W-1:0] RT_MIN  = 8'hF8;
  localparam logic [BYTE_W-1:0] CLR_MIN = 8'hC0;

  localparam logic [KIND_W-1:0] KIND_OFF = 4'h8;
  localparam logic [KIND_W-1:0] KIND_ON  = 4'h9;
  localparam logic [KIND_W-1:0] KIND_CC  = 4'hB;

  typedef enum logic [1:0] {
    CLS_DATA,
    CLS_VOICE,
    CLS_CLEAR,
    CLS_RT
  } byte_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_D1,
    PH_D2
  } data_ph_e;
endpackage

// File: rtl/midi_byte_class.sv
module midi_byte_class
  import midi_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output byte_cls_e         cls_o
);
  always_comb begin
    if (!byte_i[BYTE_W-1])      cls_o = CLS_DATA;
    else if (byte_i >= RT_MIN)  cls_o = CLS_RT;
    else if (byte_i >= CLR_MIN) cls_o = CLS_CLEAR;
    else                        cls_o = CLS_VOICE;
  end
endmodule

// File: rtl/midi_rs_track.sv
module midi_rs_track
  import midi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  byte_cls_e         cls_i,
  output logic [BYTE_W-1:0] rs_o,
  output logic [DATA_W-1:0] num_o,
  output logic              pair_o
);
  logic [BYTE_W-1:0] rs_q;
  logic [DATA_W-1:0] num_q;
  data_ph_e          ph_q;
  logic              has_rs;

  assign has_rs = (rs_q != '0);
  assign pair_o = valid_i && (cls_i == CLS_DATA) && has_rs && (ph_q == PH_D2);
  assign rs_o   = rs_q;
  assign num_o  = num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q  <= '0;
      num_q <= '0;
      ph_q  <= PH_IDLE;
    end else if (valid_i) begin
      unique case (cls_i)
        CLS_CLEAR: begin
          rs_q <= '0;
          ph_q <= PH_IDLE;
        end
        CLS_VOICE: begin
          rs_q <= byte_i;
          ph_q <= PH_D1;
        end
        CLS_DATA: begin
          if (has_rs) begin
            if (ph_q == PH_D2) begin
              ph_q <= PH_D1;
            end else begin
              num_q <= byte_i[DATA_W-1:0];
              ph_q  <= PH_D2;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/midi_evt_gen.sv
module midi_evt_gen
  import midi_pkg::*;
#(
  parameter bit VEL0_OFF = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_i,
  input  logic [BYTE_W-1:0] rs_i,
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              note_evt_o,
  output logic              note_on_o,
  output logic [BYTE_W-1:0] note_status_o,
  output logic [DATA_W-1:0] note_num_o,
  output logic [DATA_W-1:0] note_vel_o,
  output logic              cc_evt_o,
  output logic [DATA_W-1:0] cc_num_o,
  output logic [DATA_W-1:0] cc_val_o
);
  logic [KIND_W-1:0] kind;
  logic              chan_ok, is_note, is_cc, on_d;

  assign kind    = rs_i[BYTE_W-1:CHAN_W];
  assign chan_ok = (rs_i[CHAN_W-1:0] == chan_i);
  assign is_note = pair_i && chan_ok && ((kind == KIND_OFF) || (kind == KIND_ON));
  assign is_cc   = pair_i && chan_ok && (kind == KIND_CC);

  generate
    if (VEL0_OFF) begin : g_vel0_off
      assign on_d = (kind == KIND_ON) && (val_i != '0);
    end else begin : g_vel0_on
      assign on_d = (kind == KIND_ON);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      note_evt_o    <= 1'b0;
      note_on_o     <= 1'b0;
      note_status_o <= '0;
      note_num_o    <= '0;
      note_vel_o    <= '0;
      cc_evt_o      <= 1'b0;
      cc_num_o      <= '0;
      cc_val_o      <= '0;
    end else begin
      note_evt_o <= is_note;
      cc_evt_o   <= is_cc;
      if (is_note) begin
        note_on_o     <= on_d;
        note_status_o <= rs_i;
        note_num_o    <= num_i;
        note_vel_o    <= val_i;
      end
      if (is_cc) begin
        cc_num_o <= num_i;
        cc_val_o <= val_i;
      end
    end
  end
endmodule

// File: rtl/midi_rs_parser.sv
module midi_rs_parser
  import midi_pkg::*;
#(
  parameter bit VEL0_OFF = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              note_evt_o,
  output logic              note_on_o,
  output logic [BYTE_W-1:0] note_status_o,
  output logic [DATA_W-1:0] note_num_o,
  output logic [DATA_W-1:0] note_vel_o,
  output logic              cc_evt_o,
  output logic [DATA_W-1:0] cc_num_o,
  output logic [DATA_W-1:0] cc_val_o
);
  byte_cls_e         cls;
  logic [BYTE_W-1:0] rs_q;
  logic [DATA_W-1:0] num_q;
  logic              pair;

  midi_byte_class u_cls (
    .byte_i (byte_i),
    .cls_o  (cls)
  );

  midi_rs_track u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (byte_valid_i),
    .byte_i  (byte_i),
    .cls_i   (cls),
    .rs_o    (rs_q),
    .num_o   (num_q),
    .pair_o  (pair)
  );

  midi_evt_gen #(.VEL0_OFF(VEL0_OFF)) u_evt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pair_i        (pair),
    .rs_i          (rs_q),
    .num_i         (num_q),
    .val_i         (byte_i[DATA_W-1:0]),
    .chan_i        (chan_i),
    .note_evt_o    (note_evt_o),
    .note_on_o     (note_on_o),
    .note_status_o (note_status_o),
    .note_num_o    (note_num_o),
    .note_vel_o    (note_vel_o),
    .cc_evt_o      (cc_evt_o),
    .cc_num_o      (cc_num_o),
    .cc_val_o      (cc_val_o)
  );
endmodule

// File: rtl/midi_rs_parser_chk.sv
module midi_rs_parser_chk
  import midi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] byte_i,
  input logic              byte_valid_i,
  input logic              note_evt_o,
  input logic              cc_evt_o,
  input logic [BYTE_W-1:0] rs_q
);
  // R11
  note_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    note_evt_o |=> !note_evt_o);
  // R11
  cc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_evt_o |=> !cc_evt_o);
  // R8
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(note_evt_o && cc_evt_o));
  // R6
  evt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (note_evt_o || cc_evt_o) |-> $past(byte_valid_i && !byte_i[7]));
  // R3
  rt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_i >= 8'hF8) |=> ($stable(rs_q) && !note_evt_o && !cc_evt_o));
  // R2
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_i >= 8'hC0 && byte_i <= 8'hF7) |=> (rs_q == 8'h00));
  // R4
  store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_i >= 8'h80 && byte_i <= 8'hBF) |=> (rs_q == $past(byte_i)));
  // R5
  no_rs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !byte_i[7] && rs_q == 8'h00) |=> (!note_evt_o && !cc_evt_o));
endmodule

bind midi_rs_parser midi_rs_parser_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_i       (byte_i),
  .byte_valid_i (byte_valid_i),
  .note_evt_o   (note_evt_o),
  .cc_evt_o     (cc_evt_o),
  .rs_q         (rs_q)
);

// File: tb/sim_midi_rs_parser.sv
`timescale 1ns/1ps
module sim_midi_rs_parser;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_valid_i = 1'b0;
  logic [3:0] chan_i = 4'h0;
  logic       note_evt_o, note_on_o, cc_evt_o;
  logic [7:0] note_status_o;
  logic [6:0] note_num_o, note_vel_o, cc_num_o, cc_val_o;

  always #2 clk_i = ~clk_i;

  midi_rs_parser u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .chan_i(chan_i), .note_evt_o(note_evt_o), .note_on_o(note_on_o),
    .note_status_o(note_status_o), .note_num_o(note_num_o), .note_vel_o(note_vel_o),
    .cc_evt_o(cc_evt_o), .cc_num_o(cc_num_o), .cc_val_o(cc_val_o)
  );

  typedef struct {
    bit         is_cc;
    bit         on;
    logic [7:0] st;
    logic [6:0] num;
    logic [6:0] val;
    string      req;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    fails = 0;
  string phase = "R1";
  logic  prev_note = 1'b0, prev_cc = 1'b0;
  bit    done = 1'b0;

  task automatic exp_note(bit on, logic [7:0] st, logic [6:0] n, logic [6:0] v, string r);
    exp_t e;
    e.is_cc = 1'b0; e.on = on; e.st = st; e.num = n; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic exp_cc(logic [6:0] n, logic [6:0] v, string r);
    exp_t e;
    e.is_cc = 1'b1; e.on = 1'b0; e.st = 8'h00; e.num = n; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk_i);
    byte_valid_i = 1'b1;
    byte_i = b;
  endtask

  task automatic idle();
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    byte_i = 8'h5A;
  endtask

  task automatic sendg(logic [7:0] b);
    send(b);
    idle();
  endtask

  task automatic drain(string r);
    repeat (4) @(negedge clk_i);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected events missing, expected 0", r, q.size());
      q.delete();
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (note_evt_o && prev_note) begin
        checks++; fails++;
        $display("FAIL R11: note_evt_o high two cycles, expected one");
      end
      if (cc_evt_o && prev_cc) begin
        checks++; fails++;
        $display("FAIL R11: cc_evt_o high two cycles, expected one");
      end
      if (note_evt_o || cc_evt_o) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected event note=%0b cc=%0b, expected none",
                   phase, note_evt_o, cc_evt_o);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_cc) begin
            if (!cc_evt_o || note_evt_o || cc_num_o != e.num || cc_val_o != e.val) begin
              fails++;
              $display("FAIL %s: cc act evt=%0b num=%h val=%h, exp num=%h val=%h",
                       e.req, cc_evt_o, cc_num_o, cc_val_o, e.num, e.val);
            end
          end else begin
            if (!note_evt_o || cc_evt_o || note_on_o != e.on || note_status_o != e.st ||
                note_num_o != e.num || note_vel_o != e.val) begin
              fails++;
              $display("FAIL %s: note act evt=%0b on=%0b st=%h num=%h vel=%h, exp on=%0b st=%h num=%h vel=%h",
                       e.req, note_evt_o, note_on_o, note_status_o, note_num_o, note_vel_o,
                       e.on, e.st, e.num, e.val);
            end
          end
        end
      end
      prev_note <= note_evt_o;
      prev_cc   <= cc_evt_o;
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (note_evt_o || cc_evt_o) begin
      fails++;
      $display("FAIL R1: events %0b%0b in reset, expected 00", note_evt_o, cc_evt_o);
    end
    rst_ni = 1'b1;
    idle();
    checks++;
    if (note_evt_o || cc_evt_o) begin
      fails++;
      $display("FAIL R1: events %0b%0b after reset, expected 00", note_evt_o, cc_evt_o);
    end

    // R5 / R1: data with zero running status
    phase = "R5";
    sendg(8'h3C); sendg(8'h40); sendg(8'h41);
    drain("R5");

    // R4 R6 R8: note on
    phase = "R6";
    exp_note(1'b1, 8'h90, 7'h3C, 7'h40, "R6");
    sendg(8'h90); sendg(8'h3C); sendg(8'h40);
    drain("R6");

    // R7: running status reuse
    phase = "R7";
    exp_note(1'b1, 8'h90, 7'h3E, 7'h50, "R7");
    exp_note(1'b1, 8'h90, 7'h3F, 7'h01, "R7");
    sendg(8'h3E); sendg(8'h50); sendg(8'h3F); sendg(8'h01);
    drain("R7");

    // R10: velocity zero on 0x9n
    phase = "R10";
    exp_note(1'b0, 8'h90, 7'h3E, 7'h00, "R10");
    sendg(8'h3E); sendg(8'h00);
    exp_note(1'b0, 8'h80, 7'h30, 7'h20, "R10");
    sendg(8'h80); sendg(8'h30); sendg(8'h20);
    drain("R10");

    // R8: control change
    phase = "R8";
    exp_cc(7'h07, 7'h64, "R8");
    sendg(8'hB0); sendg(8'h07); sendg(8'h64);
    drain("R8");

    // R3: real-time bytes inside a pair
    phase = "R3";
    exp_cc(7'h01, 7'h02, "R3");
    sendg(8'hB0); sendg(8'hFE); sendg(8'h01); sendg(8'hF8); sendg(8'hFF); sendg(8'h02);
    drain("R3");

    // R2: clear ranges
    phase = "R2";
    sendg(8'hC0); sendg(8'h05); sendg(8'h3C); sendg(8'h40);
    sendg(8'h90); sendg(8'hF2); sendg(8'h3C); sendg(8'h40);
    sendg(8'h90); sendg(8'h3C); sendg(8'hF7); sendg(8'h40); sendg(8'h41);
    drain("R2");

    // R9: channel mismatch, then retune channel
    phase = "R9";
    sendg(8'h91); sendg(8'h3C); sendg(8'h40);
    drain("R9");
    chan_i = 4'h1;
    exp_note(1'b1, 8'h91, 7'h3D, 7'h41, "R9");
    sendg(8'h3D); sendg(8'h41);
    sendg(8'h92); sendg(8'h3C); sendg(8'h40);
    sendg(8'hB0); sendg(8'h07); sendg(8'h10);
    drain("R9");
    chan_i = 4'h0;

    // R4: new status mid-pair restarts; R8: 0xA0 filtered
    phase = "R4";
    exp_cc(7'h07, 7'h10, "R4");
    sendg(8'h90); sendg(8'h3C); sendg(8'hB0); sendg(8'h07); sendg(8'h10);
    drain("R4");
    phase = "R8";
    sendg(8'hA0); sendg(8'h3C); sendg(8'h40);
    drain("R8");

    // R11: back-to-back burst, pulse overlaps next byte acceptance
    phase = "R11";
    exp_note(1'b1, 8'h90, 7'h40, 7'h7F, "R11");
    exp_note(1'b1, 8'h90, 7'h41, 7'h7E, "R11");
    exp_cc(7'h0A, 7'h33, "R11");
    exp_note(1'b0, 8'h80, 7'h42, 7'h11, "R11");
    send(8'h90); send(8'h40); send(8'h7F); send(8'h41); send(8'hF8); send(8'h7E);
    send(8'hB0); send(8'h0A); send(8'h33); send(8'h80); send(8'h42); send(8'h11);
    idle();
    drain("R11");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule